// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Operation Decoder

This block is the combinational arithmetic core of a simple processor datapath. It takes two 32-bit operands and a short operation request, and returns a 32-bit result together with a flag that shows whether that result is all zeros. The request has two parts. The first is a 2-bit operation class from the main instruction decoder. The second is the 6-bit function field of register-to-register instructions.

Inside the block, a decoder folds the class and the function field into a 3-bit operation select. The value 110 selects subtract, so bit 2 of the select acts as the invert-second-operand and carry-in control of a single shared adder. Set-on-less-than reuses that adder's difference. Memory-address computation uses the add path. Branch comparison uses the subtract path together with the zero flag. There is no clock, and every output follows the inputs within the same cycle.

Top module: `alu_unit`

## Requirements
- R1: With operation class 00, the block adds the operands (internal select 010) whatever the function field holds.
- R2: With operation class 01, the block subtracts the second operand from the first (select 110) whatever the function field holds.
- R3: Operation class 11 also subtracts (select 110), because any class with bit 0 set means subtract, and the function field has no effect.
- R4: With operation class 10, the low four bits of the function field choose the operation: 0000 add, 0010 subtract, 0100 AND, 0101 OR, 1010 set-on-less-than. The upper two bits of the field are ignored.
- R5: With class 10 and any other low-four-bit pattern, the block adds.
- R6: AND and OR act bitwise over all 32 bits.
- R7: Add and subtract wrap modulo 2^32 and give no overflow indication.
- R8: Set-on-less-than compares the operands as signed two's-complement numbers. It returns 1 when the first is smaller and 0 otherwise, with bits 31..1 always zero. The result is correct even when the operand difference overflows.
- R9: The zero output is 1 exactly when the 32-bit result is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_class | input | 2 | Operation class from the main decoder |
| funct | input | 6 | Function field of register-type instructions |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The zero flag and the arithmetic result are produced in the same evaluation, and both depend on the shared adder. A comparison by subtraction of equal operands therefore gives a zero result and a raised flag in one cycle. The bench provokes this case and others:

- a subtraction of equal operands;
- an add that wraps 0xFFFFFFFF + 1 to zero;
- a set-on-less-than whose answer is false.

For every such case, the scoreboard compares the result word and the flag against its own model in the same sample. The signed-overflow comparison 0x80000000 < 0x7FFFFFFF is also driven. That case checks that the less-than output and the wrapped difference are judged separately.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W   = 32;
    localparam int FUNCT_W  = 6;
    localparam int CLASS_W  = 2;
    localparam int KEY_W    = 4;

    typedef enum logic [2:0] {
        SEL_AND = 3'b000,
        SEL_OR  = 3'b001,
        SEL_ADD = 3'b010,
        SEL_SUB = 3'b110,
        SEL_SLT = 3'b111
    } op_sel_e;

    typedef enum logic [CLASS_W-1:0] {
        CLS_MEM   = 2'b00,
        CLS_BRCH  = 2'b01,
        CLS_REG   = 2'b10,
        CLS_JUMP  = 2'b11
    } op_class_e;

    typedef struct packed {
        logic [DATA_W-1:0] sum;
        logic              less;
    } arith_out_t;

    function automatic op_sel_e decode_key(input logic [KEY_W-1:0] key);
        case (key)
            4'b0000: decode_key = SEL_ADD;
            4'b0010: decode_key = SEL_SUB;
            4'b0100: decode_key = SEL_AND;
            4'b0101: decode_key = SEL_OR;
            4'b1010: decode_key = SEL_SLT;
            default: decode_key = SEL_ADD;
        endcase
    endfunction

endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
    import alu_pkg::*;
#(
    parameter int FW = FUNCT_W
) (
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FW-1:0]      funct,
    output op_sel_e            sel
);
    localparam int KW = (FW < KEY_W) ? FW : KEY_W;

    logic [KEY_W-1:0] key;

    always_comb begin
        key = '0;
        key[KW-1:0] = funct[KW-1:0];
    end

    always_comb begin
        if (op_class[0])
            sel = SEL_SUB;
        else if (op_class[1])
            sel = decode_key(key);
        else
            sel = SEL_ADD;
    end

    always_comb begin
        // R1
        cls_mem_add_chk: assert (op_class != CLS_MEM || sel == SEL_ADD);
        // R2
        cls_odd_sub_chk: assert (!op_class[0] || sel == SEL_SUB);
        // R5
        sel_legal_chk: assert (sel inside {SEL_AND, SEL_OR, SEL_ADD, SEL_SUB, SEL_SLT});
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_b,
    output logic [W-1:0] sum,
    output logic         less
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = b ^ {W{invert_b}};
        sum   = a + b_eff + {{(W-1){1'b0}}, invert_b};
        // signed a<b: signs differ -> a's sign, else sign of difference
        less  = (a[W-1] != b[W-1]) ? a[W-1] : sum[W-1];
    end

endmodule

// File: rtl/alu_unit.sv
module alu_unit
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FUNCT_W-1:0] funct,
    output logic [DATA_W-1:0]  result,
    output logic               zero
);
    op_sel_e           sel;
    arith_out_t        arith;
    logic [DATA_W-1:0] and_bits;
    logic [DATA_W-1:0] or_bits;

    alu_op_decoder #(.FW(FUNCT_W)) u_dec (
        .op_class (op_class),
        .funct    (funct),
        .sel      (sel)
    );

    alu_addsub #(.W(DATA_W)) u_addsub (
        .a        (opnd_a),
        .b        (opnd_b),
        .invert_b (sel[2]),
        .sum      (arith.sum),
        .less     (arith.less)
    );

    for (genvar i = 0; i < DATA_W; i++) begin : g_logic
        assign and_bits[i] = opnd_a[i] & opnd_b[i];
        assign or_bits[i]  = opnd_a[i] | opnd_b[i];
    end

    always_comb begin
        case (sel)
            SEL_AND: result = and_bits;
            SEL_OR:  result = or_bits;
            SEL_SLT: result = {{(DATA_W-1){1'b0}}, arith.less};
            default: result = arith.sum;
        endcase
        zero = ~|result;
    end

    always_comb begin
        // R8
        slt_range_chk: assert (sel != SEL_SLT || result <= 1);
        // R9
        eq_sub_zero_chk: assert (!(sel == SEL_SUB && opnd_a == opnd_b) || zero);
    end

endmodule

// File: tb/test_alu_unit.sv
module test_alu_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [1:0]  op_class = '0;
    logic [5:0]  funct = '0;
    logic [31:0] result;
    logic        zero;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] res;
        logic        z;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    alu_unit i_alu_unit (
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .op_class (op_class),
        .funct    (funct),
        .result   (result),
        .zero     (zero)
    );

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [1:0] c, input logic [5:0] f);
        logic [2:0] op;
        if (c == 2'b00) op = 3'd0;
        else if (c[0])  op = 3'd1;
        else begin
            case (f[3:0])
                4'h0: op = 3'd0;
                4'h2: op = 3'd1;
                4'h4: op = 3'd2;
                4'h5: op = 3'd3;
                4'hA: op = 3'd4;
                default: op = 3'd0;
            endcase
        end
        case (op)
            3'd1: model = a - b;
            3'd2: model = a & b;
            3'd3: model = a | b;
            3'd4: model = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: model = a + b;
        endcase
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] c, input logic [5:0] f, input string tag);
        exp_t e;
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_class = c; funct = f;
        e.res = model(a, b, c, f);
        e.z   = (e.res == 32'd0);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    always @(posedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (result !== e.res || zero !== e.z) begin
                n_bad++;
                $display("FAIL %s: got result=%h zero=%b, expected result=%h zero=%b",
                         e.tag, result, zero, e.res, e.z);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero inputs, class 00 adds 0+0
        drive(32'h0, 32'h0, 2'b00, 6'h00, "R1/R9 reset");
        drive(32'd5, 32'd3, 2'b00, 6'h22, "R1 mem ignores funct");
        drive(32'd7, 32'd7, 2'b01, 6'h20, "R2 branch equal");
        drive(32'd9, 32'd4, 2'b01, 6'h25, "R2 branch diff");
        drive(32'd10, 32'd3, 2'b11, 6'h25, "R3 class11 sub");
        drive(32'd20, 32'd22, 2'b10, 6'h20, "R4 add");
        drive(32'd20, 32'd22, 2'b10, 6'h22, "R4 sub");
        drive(32'hF0F0_1234, 32'h0FF0_FF00, 2'b10, 6'h24, "R6 and");
        drive(32'hF000_0001, 32'h000F_0010, 2'b10, 6'h25, "R6 or");
        drive(32'hA5A5_0000, 32'h5A5A_0000, 2'b10, 6'h24, "R6/R9 and zero");
        drive(32'd2, 32'd9, 2'b10, 6'h0A, "R4 upper funct ignored slt");
        drive(32'd2, 32'd9, 2'b10, 6'h27, "R5 unlisted add");
        drive(32'd2, 32'd9, 2'b10, 6'h3F, "R5 unlisted add 2");
        drive(32'hFFFF_FFFF, 32'd1, 2'b00, 6'h00, "R7/R9 wrap add");
        drive(32'd0, 32'd1, 2'b01, 6'h00, "R7 wrap sub");
        drive(32'hFFFF_FFFF, 32'd1, 2'b10, 6'h2A, "R8 slt neg<pos");
        drive(32'd1, 32'hFFFF_FFFF, 2'b10, 6'h2A, "R8/R9 slt false");
        drive(32'h8000_0000, 32'h7FFF_FFFF, 2'b10, 6'h2A, "R8 slt overflow");
        drive(32'h7FFF_FFFF, 32'h8000_0000, 2'b10, 6'h2A, "R8 slt overflow rev");
        drive(32'd5, 32'd5, 2'b10, 6'h2A, "R8 slt equal");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule